// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block is the command front end of a burst-capable NOR flash. It watches single-cycle bus writes (address plus 16-bit data) and recognises command sequences that begin with two fixed key cycles. From these it tracks the operating mode: array reading, identification (autoselect), busy with an embedded program or erase, reading while an erase is suspended, or a sticky error. The memory array and the embedded algorithms are not modelled. The surrounding logic reports the end of an operation on `op_done` and a failed operation on `op_fail`.

The block also holds the burst configuration register. A dedicated three-cycle sequence loads it, and the code comes from the upper address bits rather than from the data bus. The top bit of this register enables synchronous burst reads. Its other bits hold the wait-state count, the burst wrap, the active clock edge and the ready-signal timing. The block stores these bits but does not interpret them. The register refuses new codes unless the device is in plain array-read mode.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: After `rst_n` is asserted (asynchronous, active low), `mode` is 0 (read-array), `cfg_reg` is 8'h04 and `sync_mode` is 0.
- R2: The key cycles are data AAh at address 555h, then data 55h at address 2AAh. Only address bits 11..0 and data bits 7..0 are decoded. A third write of C0h at 555h loads address bits 19..12 into `cfg_reg`, and the new value is visible in the cycle after the write.
- R3: `sync_mode` equals `cfg_reg` bit 7. It rises only through a configuration load whose address bit 19 is 1.
- R4: A configuration load has no effect unless `mode` is read-array (0). This holds when the mode is busy, erase-suspended, autoselect or error.
- R5: A write that does not match the first or the second key cycle abandons the sequence silently. The mode stays as it was and no error results.
- R6: After both key cycles, a third write with an unknown command or a wrong address gives `mode` 4 (error). So does a write that breaks the erase sequence. The error mode is left only through the reset command.
- R7: A write with data F0h is the reset command in any position of a sequence. It returns the device to read-array (0), or to erase-suspend-read (3) when an erase is suspended. The reset command is ignored while `mode` is busy (2).
- R8: Keys then A0h, followed by one write of any address and data, start a program and give `mode` 2. Keys, 80h, keys again, then 30h (sector) or 10h (chip) start an erase and give `mode` 2.
- R9: In busy mode, `op_fail` leads to error (4) and takes priority over `op_done`. `op_done` leads to read-array, or to erase-suspend-read when the program was started from a suspended erase. Both inputs are ignored outside busy mode.
- R10: A single write of B0h during an erase gives erase-suspend-read (3). A single write of 30h in that mode resumes the erase (busy, 2). A B0h write during a program is ignored.
- R11: Keys then 90h at 555h give `mode` 1 (autoselect).
- R12: If a program started from a suspended erase fails, the reset command leads back to erase-suspend-read (3). After an erase that was not suspended fails, it leads to read-array (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | 20 | Write address |
| wr_data | input | 16 | Write data |
| op_done | input | 1 | Embedded operation finished |
| op_fail | input | 1 | Embedded operation failed |
| mode | output | 3 | 0 read, 1 autoselect, 2 busy, 3 erase-suspend-read, 4 error |
| cfg_reg | output | 8 | Burst configuration register |
| sync_mode | output | 1 | Synchronous burst reads enabled |

## Verification
The hardest state to reach is an error raised by a program that was itself started inside a suspended erase. From there the reset command must land in erase-suspend-read and not in read-array. The bench gets there in steps: it issues a full six-write erase, suspends it with B0h, runs the program sequence, and then pulses `op_fail`. Because completion and failure are plain inputs, the stimulus places them in the exact cycle it needs. It then tries a configuration load while in that error state and checks that the register did not move.

// File: rtl/nor_cmd_pkg.sv
`timescale 1ns/1ps
package nor_cmd_pkg;
  localparam int unsigned LOW_W = 12;
  localparam logic [LOW_W-1:0] KEY1_ADDR = 12'h555;
  localparam logic [LOW_W-1:0] KEY2_ADDR = 12'h2AA;
  localparam logic [7:0] KEY1_DATA   = 8'hAA;
  localparam logic [7:0] KEY2_DATA   = 8'h55;
  localparam logic [7:0] OP_PROGRAM  = 8'hA0;
  localparam logic [7:0] OP_ERASE    = 8'h80;
  localparam logic [7:0] OP_IDENT    = 8'h90;
  localparam logic [7:0] OP_CONFIG   = 8'hC0;
  localparam logic [7:0] OP_RESET    = 8'hF0;
  localparam logic [7:0] OP_SUSPEND  = 8'hB0;
  localparam logic [7:0] OP_SECTOR   = 8'h30;
  localparam logic [7:0] OP_CHIP     = 8'h10;

  typedef enum logic [2:0] {
    MODE_READ    = 3'd0,
    MODE_AUTOSEL = 3'd1,
    MODE_BUSY    = 3'd2,
    MODE_SUSP    = 3'd3,
    MODE_ERROR   = 3'd4
  } mode_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_KEY1, SQ_CMD, SQ_PGM, SQ_EKEY0, SQ_EKEY1, SQ_ECMD
  } seq_e;

  typedef struct packed {
    logic rst_cmd;
    logic prog;
    logic erase;
    logic autosel;
    logic cfg_load;
    logic bad;
    logic suspend;
    logic resume;
  } cmd_ev_t;

  function automatic logic key_hit(input logic [LOW_W-1:0] a, input logic [7:0] d,
                                   input logic [LOW_W-1:0] wa, input logic [7:0] wd);
    return (a == wa) && (d == wd);
  endfunction

  function automatic logic is_erase_kind(input logic [7:0] d);
    return (d == OP_SECTOR) || (d == OP_CHIP);
  endfunction
endpackage

// File: rtl/nor_seq_decode.sv
`timescale 1ns/1ps
module nor_seq_decode
  import nor_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned CFG_W = ADDR_W - LOW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output cmd_ev_t           ev,
  output logic [CFG_W-1:0]  cfg_code
);
  seq_e seq_q, seq_d;
  logic [LOW_W-1:0] lo_addr;
  logic [7:0]       cmd_byte;
  logic             unused_hi_data;

  assign lo_addr        = wr_addr[LOW_W-1:0];
  assign cmd_byte       = wr_data[7:0];
  assign cfg_code       = wr_addr[ADDR_W-1:LOW_W];
  assign unused_hi_data = ^wr_data[DATA_W-1:8];

  always_comb begin
    ev    = '0;
    seq_d = seq_q;
    if (wr_en) begin
      if (cmd_byte == OP_RESET) begin
        ev.rst_cmd = 1'b1;
        seq_d      = SQ_IDLE;
      end else begin
        unique case (seq_q)
          SQ_IDLE: begin
            if (key_hit(lo_addr, cmd_byte, KEY1_ADDR, KEY1_DATA)) seq_d = SQ_KEY1;
            else if (cmd_byte == OP_SUSPEND) ev.suspend = 1'b1;
            else if (cmd_byte == OP_SECTOR)  ev.resume  = 1'b1;
          end
          SQ_KEY1: seq_d = key_hit(lo_addr, cmd_byte, KEY2_ADDR, KEY2_DATA) ? SQ_CMD : SQ_IDLE;
          SQ_CMD: begin
            seq_d = SQ_IDLE;
            if (lo_addr != KEY1_ADDR) ev.bad = 1'b1;
            else begin
              unique case (cmd_byte)
                OP_PROGRAM: seq_d = SQ_PGM;
                OP_ERASE:   seq_d = SQ_EKEY0;
                OP_IDENT:   ev.autosel  = 1'b1;
                OP_CONFIG:  ev.cfg_load = 1'b1;
                default:    ev.bad      = 1'b1;
              endcase
            end
          end
          SQ_PGM: begin
            ev.prog = 1'b1;
            seq_d   = SQ_IDLE;
          end
          SQ_EKEY0: begin
            if (key_hit(lo_addr, cmd_byte, KEY1_ADDR, KEY1_DATA)) seq_d = SQ_EKEY1;
            else begin ev.bad = 1'b1; seq_d = SQ_IDLE; end
          end
          SQ_EKEY1: begin
            if (key_hit(lo_addr, cmd_byte, KEY2_ADDR, KEY2_DATA)) seq_d = SQ_ECMD;
            else begin ev.bad = 1'b1; seq_d = SQ_IDLE; end
          end
          SQ_ECMD: begin
            seq_d = SQ_IDLE;
            if (is_erase_kind(cmd_byte)) ev.erase = 1'b1;
            else ev.bad = 1'b1;
          end
          default: seq_d = SQ_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seq_q <= SQ_IDLE;
    else        seq_q <= seq_d;
  end

  // R6: at most one command event per write
  assert_one_event_R6: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(ev));
  // R5: after the command cycle the tracker is idle or inside a longer sequence
  assert_cmd_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_q == SQ_CMD && wr_en) |=> (seq_q == SQ_IDLE || seq_q == SQ_PGM || seq_q == SQ_EKEY0));
endmodule

// File: rtl/nor_mode_ctrl.sv
`timescale 1ns/1ps
module nor_mode_ctrl
  import nor_cmd_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  cmd_ev_t ev,
  input  logic    op_done,
  input  logic    op_fail,
  output mode_e   mode
);
  mode_e mode_q, mode_d, home_mode;
  logic  susp_q, susp_d;
  logic  erasing_q, erasing_d;
  logic  ev_take_suspend;

  assign home_mode       = susp_q ? MODE_SUSP : MODE_READ;
  assign ev_take_suspend = (mode_q == MODE_BUSY) && erasing_q && ev.suspend && !op_done && !op_fail;
  assign mode            = mode_q;

  always_comb begin
    mode_d    = mode_q;
    susp_d    = susp_q;
    erasing_d = erasing_q;
    unique case (mode_q)
      MODE_READ: begin
        if (ev.prog)         begin mode_d = MODE_BUSY; erasing_d = 1'b0; end
        else if (ev.erase)   begin mode_d = MODE_BUSY; erasing_d = 1'b1; end
        else if (ev.autosel) mode_d = MODE_AUTOSEL;
        else if (ev.bad)     mode_d = MODE_ERROR;
      end
      MODE_AUTOSEL: if (ev.rst_cmd) mode_d = home_mode;
      MODE_BUSY: begin
        if (op_fail)              mode_d = MODE_ERROR;
        else if (op_done)         mode_d = home_mode;
        else if (ev_take_suspend) begin mode_d = MODE_SUSP; susp_d = 1'b1; end
      end
      MODE_SUSP: begin
        if (ev.prog)                   begin mode_d = MODE_BUSY; erasing_d = 1'b0; end
        else if (ev.resume)            begin mode_d = MODE_BUSY; erasing_d = 1'b1; susp_d = 1'b0; end
        else if (ev.autosel)           mode_d = MODE_AUTOSEL;
        else if (ev.bad || ev.erase)   mode_d = MODE_ERROR;
      end
      MODE_ERROR: if (ev.rst_cmd) mode_d = home_mode;
      default: mode_d = MODE_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MODE_READ;
      susp_q    <= 1'b0;
      erasing_q <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      susp_q    <= susp_d;
      erasing_q <= erasing_d;
    end
  end

  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_BUSY && !op_done && !op_fail && !ev.suspend) |=> mode_q == MODE_BUSY);
  assert_fail_error_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_BUSY && op_fail) |=> mode_q == MODE_ERROR);
  assert_error_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_ERROR && !ev.rst_cmd) |=> mode_q == MODE_ERROR);
  assert_reset_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MODE_ERROR || mode_q == MODE_AUTOSEL) && ev.rst_cmd)
      |=> (mode_q == MODE_READ || mode_q == MODE_SUSP));
  assert_suspend_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_take_suspend |=> mode_q == MODE_SUSP);
endmodule

// File: rtl/nor_cfg_reg.sv
`timescale 1ns/1ps
module nor_cfg_reg
  import nor_cmd_pkg::*;
#(
  parameter int unsigned CFG_W = 8,
  parameter logic [CFG_W-1:0] CFG_RESET = 8'h04
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_req,
  input  logic [CFG_W-1:0] code,
  input  mode_e            mode,
  output logic [CFG_W-1:0] cfg_q
);
  logic load_ok;
  assign load_ok = load_req && (mode == MODE_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cfg_q <= CFG_RESET;
    else if (load_ok) cfg_q <= code;
  end

  assert_cfg_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_READ) |=> $stable(cfg_q));
  assert_cfg_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_ok |=> cfg_q == $past(code));
endmodule

// File: rtl/nor_cmd_ctrl.sv
`timescale 1ns/1ps
module nor_cmd_ctrl
  import nor_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 16,
  parameter logic [ADDR_W-LOW_W-1:0] CFG_RESET = 'h04
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic                    op_done,
  input  logic                    op_fail,
  output logic [2:0]              mode,
  output logic [ADDR_W-LOW_W-1:0] cfg_reg,
  output logic                    sync_mode
);
  localparam int unsigned CFG_W = ADDR_W - LOW_W;

  cmd_ev_t          ev;
  logic [CFG_W-1:0] cfg_code;
  mode_e            mode_cur;

  nor_seq_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ev(ev), .cfg_code(cfg_code)
  );

  nor_mode_ctrl u_mode (
    .clk(clk), .rst_n(rst_n), .ev(ev), .op_done(op_done), .op_fail(op_fail), .mode(mode_cur)
  );

  nor_cfg_reg #(.CFG_W(CFG_W), .CFG_RESET(CFG_RESET)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load_req(ev.cfg_load), .code(cfg_code), .mode(mode_cur),
    .cfg_q(cfg_reg)
  );

  assign mode      = mode_cur;
  assign sync_mode = cfg_reg[CFG_W-1];

  assert_sync_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_mode) |-> $past(ev.cfg_load));
endmodule

// File: tb/nor_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module nor_cmd_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [19:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        op_done = 1'b0;
  logic        op_fail = 1'b0;
  logic [2:0]  mode;
  logic [7:0]  cfg_reg;
  logic        sync_mode;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  nor_cmd_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .op_done(op_done), .op_fail(op_fail), .mode(mode), .cfg_reg(cfg_reg), .sync_mode(sync_mode)
  );

  // kind: 0 bus write, 1 done pulse, 2 fail pulse
  typedef struct packed {
    logic [3:0]  req;
    logic [1:0]  kind;
    logic [19:0] addr;
    logic [15:0] data;
    logic [2:0]  emode;
    logic [7:0]  ecfg;
  } vec_t;

  localparam int NV = 56;
  localparam vec_t VECS [NV] = '{
    '{4'd2, 2'd0, 20'h00555, 16'h00AA, 3'd0, 8'h04}, // R2
    '{4'd2, 2'd0, 20'h002AA, 16'h0055, 3'd0, 8'h04},
    '{4'd3, 2'd0, 20'h81555, 16'h00C0, 3'd0, 8'h81}, // R3 sync on
    '{4'd2, 2'd0, 20'h00555, 16'h00AA, 3'd0, 8'h81},
    '{4'd2, 2'd0, 20'h002AA, 16'h0055, 3'd0, 8'h81},
    '{4'd3, 2'd0, 20'h35555, 16'h00C0, 3'd0, 8'h35}, // R3 sync off
    '{4'd5, 2'd0, 20'h00555, 16'h00AA, 3'd0, 8'h35},
    '{4'd5, 2'd0, 20'h00123, 16'h0055, 3'd0, 8'h35}, // R5 abort
    '{4'd11,2'd0, 20'h00555, 16'h00AA, 3'd0, 8'h35},
    '{4'd11,2'd0, 20'h002AA, 16'h0055, 3'd0, 8'h35},
    '{4'd11,2'd0, 20'h00555, 16'h0090, 3'd1, 8'h35}, // R11
    '{4'd4, 2'd0, 20'h00555, 16'h00AA, 3'd1, 8'h35},
    '{4'd4, 2'd0, 20'h002AA, 16'h0055, 3'd1, 8'h35},
    '{4'd4, 2'd0, 20'hFF555, 16'h00C0, 3'd1, 8'h35}, // R4 autoselect
    '{4'd7, 2'd0, 20'h00000, 16'h00F0, 3'd0, 8'h35}, // R7
    '{4'd8, 2'd0, 20'h00555, 16'h00AA, 3'd0, 8'h35},
    '{4'd8, 2'd0, 20'h002AA, 16'h0055, 3'd0, 8'h35},
    '{4'd8, 2'd0, 20'h00555, 16'h00A0, 3'd0, 8'h35},
    '{4'd8, 2'd0, 20'h12345, 16'h1234, 3'd2, 8'h35}, // R8 program
    '{4'd7, 2'd0, 20'h00000, 16'h00F0, 3'd2, 8'h35}, // R7 ignored busy
    '{4'd4, 2'd0, 20'h00555, 16'h00AA, 3'd2, 8'h35},
    '{4'd4, 2'd0, 20'h002AA, 16'h0055, 3'd2, 8'h35},
    '{4'd4, 2'd0, 20'hFF555, 16'h00C0, 3'd2, 8'h35}, // R4 busy
    '{4'd10,2'd0, 20'h00000, 16'h00B0, 3'd2, 8'h35}, // R10 no program suspend
    '{4'd9, 2'd1, 20'h00000, 16'h0000, 3'd0, 8'h35}, // R9 done
    '{4'd8, 2'd0, 20'h00555, 16'h00AA, 3'd0, 8'h35},
    '{4'd8, 2'd0, 20'h002AA, 16'h0055, 3'd0, 8'h35},
    '{4'd8, 2'd0, 20'h00555, 16'h0080, 3'd0, 8'h35},
    '{4'd8, 2'd0, 20'h00555, 16'h00AA, 3'd0, 8'h35},
    '{4'd8, 2'd0, 20'h002AA, 16'h0055, 3'd0, 8'h35},
    '{4'd8, 2'd0, 20'h40000, 16'h0030, 3'd2, 8'h35}, // R8 sector erase
    '{4'd10,2'd0, 20'h00000, 16'h00B0, 3'd3, 8'h35}, // R10 suspend
    '{4'd4, 2'd0, 20'h00555, 16'h00AA, 3'd3, 8'h35},
    '{4'd4, 2'd0, 20'h002AA, 16'h0055, 3'd3, 8'h35},
    '{4'd4, 2'd0, 20'hFF555, 16'h00C0, 3'd3, 8'h35}, // R4 suspended
    '{4'd7, 2'd0, 20'h00000, 16'h00F0, 3'd3, 8'h35}, // R7 stays suspended
    '{4'd9, 2'd0, 20'h00555, 16'h00AA, 3'd3, 8'h35},
    '{4'd9, 2'd0, 20'h002AA, 16'h0055, 3'd3, 8'h35},
    '{4'd9, 2'd0, 20'h00555, 16'h00A0, 3'd3, 8'h35},
    '{4'd9, 2'd0, 20'h01000, 16'hABCD, 3'd2, 8'h35},
    '{4'd9, 2'd1, 20'h00000, 16'h0000, 3'd3, 8'h35}, // R9 back to suspend
    '{4'd12,2'd0, 20'h00555, 16'h00AA, 3'd3, 8'h35},
    '{4'd12,2'd0, 20'h002AA, 16'h0055, 3'd3, 8'h35},
    '{4'd12,2'd0, 20'h00555, 16'h00A0, 3'd3, 8'h35},
    '{4'd12,2'd0, 20'h01002, 16'h5555, 3'd2, 8'h35},
    '{4'd12,2'd2, 20'h00000, 16'h0000, 3'd4, 8'h35}, // R12 fail
    '{4'd4, 2'd0, 20'h00555, 16'h00AA, 3'd4, 8'h35},
    '{4'd4, 2'd0, 20'h002AA, 16'h0055, 3'd4, 8'h35},
    '{4'd4, 2'd0, 20'hFF555, 16'h00C0, 3'd4, 8'h35}, // R4 error
    '{4'd12,2'd0, 20'h00000, 16'h00F0, 3'd3, 8'h35}, // R12 to suspend
    '{4'd10,2'd0, 20'h00000, 16'h0030, 3'd2, 8'h35}, // R10 resume
    '{4'd9, 2'd1, 20'h00000, 16'h0000, 3'd0, 8'h35},
    '{4'd6, 2'd0, 20'h00555, 16'h00AA, 3'd0, 8'h35},
    '{4'd6, 2'd0, 20'h002AA, 16'h0055, 3'd0, 8'h35},
    '{4'd6, 2'd0, 20'h00555, 16'h0077, 3'd4, 8'h35}, // R6 unknown
    '{4'd7, 2'd0, 20'h00000, 16'h00F0, 3'd0, 8'h35}
  };

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic check(input string tag, input logic [2:0] em, input logic [7:0] ec);
    checks++;
    if (mode !== em || cfg_reg !== ec || sync_mode !== ec[7]) begin
      fails++;
      $display("FAIL %s: mode=%0d cfg=%h sync=%b, expected mode=%0d cfg=%h sync=%b",
               tag, mode, cfg_reg, sync_mode, em, ec, ec[7]);
    end
  endtask

  task automatic bus_write(input logic [19:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic pulse(input logic dn, input logic fl);
    @(negedge clk);
    op_done = dn; op_fail = fl;
    @(negedge clk);
    op_done = 1'b0; op_fail = 1'b0;
  endtask

  task automatic keys();
    bus_write(20'h00555, 16'h00AA);
    bus_write(20'h002AA, 16'h0055);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset state", 3'd0, 8'h04);

    for (int i = 0; i < NV; i++) begin
      unique case (VECS[i].kind)
        2'd1:    pulse(1'b1, 1'b0);
        2'd2:    pulse(1'b0, 1'b1);
        default: bus_write(VECS[i].addr, VECS[i].data);
      endcase
      check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].emode, VECS[i].ecfg);
    end

    // R6: broken erase sequence
    keys();
    bus_write(20'h00555, 16'h0080);
    bus_write(20'h00555, 16'h00AA);
    check("R6 erase prefix pending", 3'd0, 8'h35);
    bus_write(20'h002AA, 16'h0099);
    check("R6 erase sequence broken", 3'd4, 8'h35);
    bus_write(20'h00000, 16'h00F0);
    check("R7 reset leaves error", 3'd0, 8'h35);

    // R6: command at wrong address
    keys();
    bus_write(20'h002AA, 16'h00A0);
    check("R6 command address wrong", 3'd4, 8'h35);
    bus_write(20'h00000, 16'h00F0);

    // R8 chip erase, R12 unsuspended failure returns to read
    keys();
    bus_write(20'h00555, 16'h0080);
    keys();
    bus_write(20'h00555, 16'h0010);
    check("R8 chip erase busy", 3'd2, 8'h35);
    pulse(1'b0, 1'b1);
    check("R9 erase failure", 3'd4, 8'h35);
    bus_write(20'h00000, 16'h00F0);
    check("R12 reset to read", 3'd0, 8'h35);

    // R7 reset mid sequence clears tracker
    bus_write(20'h00555, 16'h00AA);
    bus_write(20'h00000, 16'h00F0);
    bus_write(20'h002AA, 16'h0055);
    bus_write(20'hFF555, 16'h00C0);
    check("R7 sequence cleared by reset", 3'd0, 8'h35);

    // R9 done outside busy ignored
    pulse(1'b1, 1'b0);
    check("R9 done ignored in read", 3'd0, 8'h35);

    // R9 fail wins over done
    keys();
    bus_write(20'h00555, 16'h00A0);
    bus_write(20'h00042, 16'h0001);
    pulse(1'b1, 1'b1);
    check("R9 fail priority", 3'd4, 8'h35);
    bus_write(20'h00000, 16'h00F0);

    // R3 sync enable, then R1 hardware reset while busy
    keys();
    bus_write(20'h80555, 16'h00C0);
    check("R3 sync enabled", 3'd0, 8'h80);
    keys();
    bus_write(20'h00555, 16'h00A0);
    bus_write(20'h00010, 16'h0002);
    check("R8 busy before hw reset", 3'd2, 8'h80);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 hardware reset while busy", 3'd0, 8'h04);

    report();
    $finish;
  end
endmodule